// File: doc/BRIEF.md
# Pruned Five-Stage CIC Decimator

This block is the first rate-reduction stage of a digital down-converter filter chain. It takes a signed 20-bit sample with 18 fractional bits from the mixer on every clock where `in_valid` is high. Five integrators run at the input rate. After every 64 accepted samples, five comb sections with a differential delay of one run at the decimated rate. The result is a signed 20-bit word whose least significant bit weighs 2^12, marked by a one-cycle `out_valid` pulse.

No multipliers are used. Each section keeps only as many bits as it needs. Every integrator register and every comb register has its own width and binary-point position. The low-order bits that fall below the next section's binary point are dropped by plain truncation. The block does not remove the large DC gain of the filter, which is 64^5. In output codes this gain comes to unity relative to input codes, so a full-scale step settles near the input code itself.

Top module: `cic5_pruned_decim`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result, `out_valid` is 0 and `out_data` is 0. All integrator, comb and counter state starts at zero.
- R2: `out_valid` is a single-cycle pulse. It is raised exactly once for every 64 accepted samples, so the number of pulses equals the number of accepted samples divided by 64, rounded down.
- R3: Integrators are kept as signed two's-complement values that wrap, with no saturation. Their (width, fraction bits), from the first to the fifth, are (49,17), (43,11), (37,5), (33,1) and (28,-4). On each accepted sample, integrator 1 adds the input shifted right arithmetically by 1. Each integrator k>1 adds the value that integrator k-1 held before that sample, arithmetically shifted right by 6, 6, 4 and 5 for k = 2 to 5.
- R4: Once per 64 accepted samples, the fifth integrator's value is taken, counting the 64th sample. That value is shifted right by 2 and passed through five comb sections, each computing y = x - x_previous with wraparound. Their (width, fraction bits) are (26,-6), (25,-7), (24,-8), (23,-9) and (23,-9). Between combs the value is shifted right by 1, 1, 1 and 0.
- R5: `out_data` is bits 22 down to 3 of the fifth comb register. It changes only in the cycle in which `out_valid` is high, and holds its value otherwise.
- R6: A cycle with `in_valid` low has no effect on any state or output, whatever `in_data` carries.
- R7: `out_valid` rises exactly 5 clock edges after the edge that accepts the 64th sample of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Sample on `in_data` is accepted on this edge |
| in_data | input | 20 | Signed input sample, 18 fractional bits |
| out_valid | output | 1 | One-cycle pulse marking a new decimated result |
| out_data | output | 20 | Signed decimated result, LSB weight 2^12 |

## Verification
Every cycle, the assertions check several properties. Integrators hold whenever `in_valid` is low. The decimation tick follows an accepted sample at the counter wrap. At most one comb section is active at a time. `out_valid` never lasts two cycles, appears exactly five cycles after the tick, and is the only time `out_data` may change. The bit-exact arithmetic of the pruned sections, with its truncation and wraparound, can only be shown by the bench's scenarios. These compare every result against an independent per-section model under an impulse, positive and negative full-scale steps, and random data with gaps in `in_valid`. The same scenarios count pulses against accepted samples and check the latency from the 64th sample.

// File: rtl/cic5_pkg.sv
`timescale 1ns/1ps
package cic5_pkg;
  localparam int NSEC   = 5;
  localparam int DIN_W  = 20;
  localparam int DIN_F  = 18;
  localparam int DOUT_W = 20;
  localparam int DOUT_F = -12;

  localparam int INT_W  [NSEC] = '{49, 43, 37, 33, 28};
  localparam int INT_F  [NSEC] = '{17, 11, 5, 1, -4};
  localparam int COMB_W [NSEC] = '{26, 25, 24, 23, 23};
  localparam int COMB_F [NSEC] = '{-6, -7, -8, -9, -9};

  localparam int INT_MAX_W  = 49;
  localparam int COMB_MAX_W = 26;

  function automatic int int_in_w(int k);
    return (k == 0) ? DIN_W : INT_W[k-1];
  endfunction

  function automatic int int_shift(int k);
    return ((k == 0) ? DIN_F : INT_F[k-1]) - INT_F[k];
  endfunction

  function automatic int comb_in_w(int k);
    return (k == 0) ? INT_W[NSEC-1] : COMB_W[k-1];
  endfunction

  function automatic int comb_shift(int k);
    return ((k == 0) ? INT_F[NSEC-1] : COMB_F[k-1]) - COMB_F[k];
  endfunction

  localparam int OUT_SHIFT = COMB_F[NSEC-1] - DOUT_F;
endpackage

// File: rtl/cic5_integ.sv
`timescale 1ns/1ps
module cic5_integ #(
  parameter int IN_W  = 20,
  parameter int W     = 49,
  parameter int SHIFT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IN_W-1:0] din,
  output logic [W-1:0]  acc
);
  localparam int TW = IN_W - SHIFT;

  logic signed [TW-1:0] kept;
  logic signed [W-1:0]  addend;
  logic [W-1:0]         acc_d, acc_q;

  assign kept   = din[IN_W-1:SHIFT];
  assign addend = W'(kept);

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + addend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R6: an idle input cycle leaves the accumulator untouched
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/cic5_comb.sv
`timescale 1ns/1ps
module cic5_comb #(
  parameter int IN_W  = 28,
  parameter int W     = 26,
  parameter int SHIFT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IN_W-1:0] din,
  output logic [W-1:0]    dout,
  output logic            vout
);
  logic [W-1:0] x;
  logic [W-1:0] dly_d, dly_q, y_d, y_q;
  logic         v_q;

  assign x = din[IN_W-1:SHIFT];

  always_comb begin
    dly_d = dly_q;
    y_d   = y_q;
    if (en) begin
      y_d   = x - dly_q;
      dly_d = x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      y_q   <= '0;
      v_q   <= 1'b0;
    end else begin
      dly_q <= dly_d;
      y_q   <= y_d;
      v_q   <= en;
    end
  end

  assign dout = y_q;
  assign vout = v_q;

  // R4: a comb section moves only when it is enabled
  p_comb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y_q) && !vout);
endmodule

// File: rtl/cic5_decim_ctrl.sv
`timescale 1ns/1ps
module cic5_decim_ctrl #(
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic tick
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             tick_d, tick_q;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (in_valid) begin
      cnt_d  = cnt_q + 1'b1;
      tick_d = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R2: a tick follows an accepted sample and lands on the counter wrap
  p_tick_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(in_valid) && (cnt_q == '0));
endmodule

// File: rtl/cic5_pruned_decim.sv
`timescale 1ns/1ps
module cic5_pruned_decim
  import cic5_pkg::*;
#(
  parameter int DEC_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DIN_W-1:0]  in_data,
  output logic              out_valid,
  output logic [DOUT_W-1:0] out_data
);
  logic [INT_MAX_W-1:0]  int_bus  [NSEC];
  logic [COMB_MAX_W-1:0] comb_bus [NSEC];
  logic [NSEC-1:0]       comb_v;
  logic                  tick;

  cic5_decim_ctrl #(.CNT_W(DEC_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tick(tick)
  );

  for (genvar k = 0; k < NSEC; k++) begin : g_int
    localparam int IW = int_in_w(k);
    localparam int W  = INT_W[k];
    logic [IW-1:0] din_w;
    logic [W-1:0]  acc_w;
    if (k == 0) begin : g_src
      assign din_w = in_data;
    end else begin : g_src
      assign din_w = int_bus[k-1][IW-1:0];
    end
    cic5_integ #(.IN_W(IW), .W(W), .SHIFT(int_shift(k))) u_integ (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .din(din_w), .acc(acc_w)
    );
    assign int_bus[k] = INT_MAX_W'($signed(acc_w));
  end

  for (genvar k = 0; k < NSEC; k++) begin : g_comb
    localparam int IW = comb_in_w(k);
    localparam int W  = COMB_W[k];
    logic [IW-1:0] din_w;
    logic [W-1:0]  y_w;
    logic          en_w;
    if (k == 0) begin : g_src
      assign din_w = int_bus[NSEC-1][IW-1:0];
      assign en_w  = tick;
    end else begin : g_src
      assign din_w = comb_bus[k-1][IW-1:0];
      assign en_w  = comb_v[k-1];
    end
    cic5_comb #(.IN_W(IW), .W(W), .SHIFT(comb_shift(k))) u_comb (
      .clk(clk), .rst_n(rst_n), .en(en_w), .din(din_w),
      .dout(y_w), .vout(comb_v[k])
    );
    assign comb_bus[k] = COMB_MAX_W'($signed(y_w));
  end

  assign out_valid = comb_v[NSEC-1];
  assign out_data  = comb_bus[NSEC-1][OUT_SHIFT+DOUT_W-1:OUT_SHIFT];

  // R2: result strobe is one cycle wide
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: output word only changes together with the strobe
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R7: only one comb section is active per cycle
  p_comb_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comb_v));

  // R7: strobe appears a fixed number of edges after the tick
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(tick, NSEC));
endmodule

// File: tb/cic5_pruned_decim_bench.sv
`timescale 1ns/1ps
module cic5_pruned_decim_bench;
  import cic5_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [19:0] in_data = '0;
  logic        out_valid;
  logic [19:0] out_data;

  always #2.5 clk = ~clk;

  cic5_pruned_decim u_cic5_pruned_decim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  int     n_acc = 0;
  int     n_out = 0;

  typedef struct { logic [19:0] data; longint at; } exp_t;
  exp_t sb[$];

  longint ig[NSEC];
  longint cd[NSEC];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint wrapw(longint v, int w);
    longint t;
    t = v <<< (64 - w);
    return t >>> (64 - w);
  endfunction

  // Reference model built from R3, R4, R5
  task automatic model_sample(logic [19:0] x);
    longint old[NSEC];
    longint v, xs;
    exp_t   e;
    for (int k = 0; k < NSEC; k++) old[k] = ig[k];
    ig[0] = wrapw(old[0] + (longint'($signed(x)) >>> 1), INT_W[0]);
    for (int k = 1; k < NSEC; k++)
      ig[k] = wrapw(old[k] + (old[k-1] >>> int_shift(k)), INT_W[k]);
    n_acc++;
    if (n_acc % 64 == 0) begin
      v = ig[NSEC-1];
      for (int k = 0; k < NSEC; k++) begin
        xs    = wrapw(v >>> comb_shift(k), COMB_W[k]);
        v     = wrapw(xs - cd[k], COMB_W[k]);
        cd[k] = xs;
      end
      e.data = 20'(wrapw(v >>> 3, 20));
      e.at   = cyc + 6;
      sb.push_back(e);
    end
  endtask

  task automatic drive(logic v, logic [19:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    if (v) model_sample(d);
  endtask

  logic [19:0] last_out = '0;
  logic        prev_v = 1'b0;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        exp_t e;
        n_out++;
        chk(!prev_v, "R2 single-cycle pulse", 1, 0);
        if (sb.size() == 0) begin
          chk(0, "R2 unexpected pulse", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(out_data == e.data, "R3 R4 R5 result value",
              longint'($signed(out_data)), longint'($signed(e.data)));
          chk(cyc == e.at, "R7 latency cycle", cyc, e.at);
        end
        last_out = out_data;
      end else begin
        chk(out_data == last_out, "R5 hold between pulses",
            longint'($signed(out_data)), longint'($signed(last_out)));
      end
      prev_v = out_valid;
    end
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NSEC; k++) begin ig[k] = 0; cd[k] = 0; end
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(out_data == '0, "R1 data in reset", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_data == '0, "R1 data after reset", out_data, 0);

    // impulse of full positive scale
    drive(1'b1, 20'h7FFFF);
    for (int i = 0; i < 64*7 - 1; i++) drive(1'b1, 20'h00000);
    // positive step
    for (int i = 0; i < 64*10; i++) drive(1'b1, 20'h3A5C3);
    // negative full-scale step
    for (int i = 0; i < 64*8; i++) drive(1'b1, 20'h80000);
    // R6: idle cycles with junk data must be ignored
    for (int i = 0; i < 150; i++) drive(1'b0, 20'($urandom));
    // random data with gaps in in_valid
    for (int i = 0; i < 64*20; ) begin
      if (($urandom % 10) < 7) begin
        drive(1'b1, 20'($urandom));
        i++;
      end else begin
        drive(1'b0, 20'($urandom));
      end
    end
    // partial block followed by idle junk (R6)
    for (int i = 0; i < 30; i++) drive(1'b1, 20'($urandom));
    for (int i = 0; i < 100; i++) drive(1'b0, 20'($urandom));
    for (int i = 0; i < 34; i++) drive(1'b1, 20'h12345);
    drive(1'b0, 20'h0);
    repeat (20) @(negedge clk);

    chk(sb.size() == 0, "R2 pending results", sb.size(), 0);
    chk(n_out == n_acc / 64, "R2 pulse count", n_out, n_acc / 64);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule